// File: doc/BRIEF.md
# Two-Port Pin Edge Interrupt Collector

This block watches two banks of general-purpose input pins and turns selected signal transitions into latched interrupt flags. Each pin has its own enable for low-to-high transitions and its own enable for high-to-low transitions. Setting both enables catches either kind. Detection looks only at the raw pin level, so it works whatever function the pin multiplexer has assigned to that pad.

Every pin input passes through a two-stage synchronizer. The synchronized level is compared with its value on the previous clock, and an enabled transition sets a sticky flag. Low-to-high and high-to-low flags are kept in separate registers. Software reads the flags per bank and clears them per pin by writing ones. A summary register shows which bank holds anything pending. All flags of both banks are ORed with an unrelated external interrupt request, and the result drives one shared interrupt line.

Register access uses a simple bus: a write strobe with an address and data, and a combinational read port. Address bit 3 selects the bank: 0 for bank A, 1 for bank B. Address bits 2:0 select the field: 0 is the low-to-high enable, 1 is the high-to-low enable, 2 is the low-to-high flags (read-only), 3 is the high-to-low flags (read-only), and 4 is the clear register (write-only, reads as zero). Address 15 is the summary register.

Top module: `gpio_edge_agg`

## Requirements
- R1: After reset, all enable registers and all flags read zero, the summary reads zero, and `irq_out` is low while `ext_irq_req` is low.
- R2: A low-to-high transition on a pin whose low-to-high enable bit is 1 sets that pin's bit in its bank's low-to-high flag register (field 2). The flag can be read after the third rising clock edge that follows the pin change.
- R3: A high-to-low transition on a pin whose high-to-low enable bit is 1 sets that pin's bit in its bank's high-to-low flag register (field 3), with the same latency as R2.
- R4: With both enables set for a pin, each transition in either direction sets the matching flag, and the two flags are held independently.
- R5: A transition whose direction is not enabled for that pin leaves every flag unchanged.
- R6: Writing the clear register (field 4) clears both flags of each pin whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R7: If an enabled transition is detected in the same cycle that the clear register clears that pin, the flag for that transition stays set.
- R8: The summary register (address 15) reads bit 0 = 1 when any bank A flag is set and bit 1 = 1 when any bank B flag is set. All other bits read 0.
- R9: `irq_out` is high whenever any flag in either bank is set or `ext_irq_req` is high, in the same cycle and with no added register.
- R10: The enable registers (fields 0 and 1) read back the value last written to them, limited to the bank's pin count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | PA_W | Bank A pin levels (asynchronous) |
| pin_b | input | PB_W | Bank B pin levels (asynchronous) |
| ext_irq_req | input | 1 | External interrupt request merged into the shared line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| irq_out | output | 1 | Shared interrupt line |

## Verification
A pin change reaches its flag register at the third rising edge: two synchronizer stages, then the flag register. The summary and `irq_out` follow in the same cycle because they are combinational. Register writes take effect at the edge that samples the strobe. The bench drives pins at the falling edge and waits four full cycles before reading status at a falling edge, so every result has settled. The edge-against-clear case is the exception: there the clear write is placed exactly in the third cycle, so that it coincides with detection.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int REG_AW = 4;
    localparam int REG_DW = 32;

    typedef enum logic [2:0] {
        F_RISE_EN = 3'd0,
        F_FALL_EN = 3'd1,
        F_RISE_ST = 3'd2,
        F_FALL_ST = 3'd3,
        F_CLEAR   = 3'd4,
        F_SUMMARY = 3'd7
    } field_e;

    localparam logic [REG_AW-1:0] SUMMARY_ADDR = 4'hF;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] went_high,
    output logic [W-1:0] went_low
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    always_comb begin
        went_high = level & ~prev_q;
        went_low  = ~level & prev_q;
    end
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
    import gpio_evt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         wr_sel,
    input  logic [2:0]   wr_field,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   rd_field,
    output logic [W-1:0] rd_val,
    output logic         any_pend
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] went_high;
    logic [W-1:0] went_low;
    logic [W-1:0] rise_en_q;
    logic [W-1:0] fall_en_q;
    logic [W-1:0] rise_flag_q;
    logic [W-1:0] fall_flag_q;
    logic [W-1:0] rise_hit;
    logic [W-1:0] fall_hit;
    logic [W-1:0] clr_mask;

    gpio_sync2 #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins),
        .sync_out (pin_sync)
    );

    gpio_edge_det #(.W(W)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (pin_sync),
        .went_high (went_high),
        .went_low  (went_low)
    );

    always_comb begin
        rise_hit = went_high & rise_en_q;
        fall_hit = went_low & fall_en_q;
        clr_mask = (wr_sel && wr_field == F_CLEAR) ? wr_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_sel) begin
            if (wr_field == F_RISE_EN) rise_en_q <= wr_data;
            if (wr_field == F_FALL_EN) fall_en_q <= wr_data;
        end
    end

    // A detected edge outranks a clear of the same pin in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_flag_q <= '0;
            fall_flag_q <= '0;
        end else begin
            rise_flag_q <= (rise_flag_q & ~clr_mask) | rise_hit;
            fall_flag_q <= (fall_flag_q & ~clr_mask) | fall_hit;
        end
    end

    always_comb begin
        unique case (rd_field)
            F_RISE_EN: rd_val = rise_en_q;
            F_FALL_EN: rd_val = fall_en_q;
            F_RISE_ST: rd_val = rise_flag_q;
            F_FALL_ST: rd_val = fall_flag_q;
            default:   rd_val = '0;
        endcase
    end

    assign any_pend = |{rise_flag_q, fall_flag_q};

    // R2 R5: a newly set low-to-high flag needs an enabled transition one cycle earlier
    a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_flag_q & ~$past(rise_flag_q) & ~$past(rise_en_q)) == '0));
    // R3 R5: the same holds for high-to-low flags
    a_r5_fall_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall_flag_q & ~$past(fall_flag_q) & ~$past(fall_en_q)) == '0));
    // R7: a detected edge sets its flag even when a clear arrives in the same cycle
    a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_hit != '0) |=> ((rise_flag_q & $past(rise_hit)) == $past(rise_hit)));
    // R6: cleared pins that had no edge end up with both flags low
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~(rise_hit | fall_hit)) != '0) |=>
        (((rise_flag_q | fall_flag_q) & $past(clr_mask & ~(rise_hit | fall_hit))) == '0));
endmodule

// File: rtl/gpio_edge_agg.sv
module gpio_edge_agg
    import gpio_evt_pkg::*;
#(
    parameter int PA_W = 32,
    parameter int PB_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-1:0]   pin_a,
    input  logic [PB_W-1:0]   pin_b,
    input  logic              ext_irq_req,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq_out
);
    localparam int BANKS = 2;

    logic [BANKS-1:0] bank_wr;
    logic [BANKS-1:0] bank_pend;
    logic [31:0]      bank_rd [BANKS];

    assign bank_wr[0] = wr_en && !wr_addr[3];
    assign bank_wr[1] = wr_en && wr_addr[3];

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            localparam int BW = (b == 0) ? PA_W : PB_W;
            logic [BW-1:0] pins_w;
            logic [BW-1:0] rd_w;
            if (b == 0) begin : g_a
                assign pins_w = pin_a;
            end else begin : g_b
                assign pins_w = pin_b;
            end

            gpio_evt_port #(.W(BW)) u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .pins     (pins_w),
                .wr_sel   (bank_wr[b]),
                .wr_field (wr_addr[2:0]),
                .wr_data  (wr_data[BW-1:0]),
                .rd_field (rd_addr[2:0]),
                .rd_val   (rd_w),
                .any_pend (bank_pend[b])
            );

            if (BW < 32) begin : g_pad
                assign bank_rd[b] = {{(32-BW){1'b0}}, rd_w};
            end else begin : g_full
                assign bank_rd[b] = rd_w;
            end
        end
    endgenerate

    always_comb begin
        if (rd_addr == SUMMARY_ADDR) rd_data = {30'd0, bank_pend};
        else                         rd_data = bank_rd[rd_addr[3]];
    end

    assign irq_out = ext_irq_req | (|bank_pend);

    // R9: the external request alone is enough to raise the shared line
    a_r9_ext_forces_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq_req |-> irq_out);
    // R8 R9: without the external request, the line is high only when a bank reports pending
    a_r8_irq_from_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ext_irq_req) |-> (bank_pend != '0));
endmodule

// File: tb/gpio_edge_agg_bench.sv
`timescale 1ns/1ps
module gpio_edge_agg_bench;
    localparam int PA_W = 32;
    localparam int PB_W = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PA_W-1:0] pin_a = '0;
    logic [PB_W-1:0] pin_b = '0;
    logic            ext_irq_req = 1'b0;
    logic            wr_en = 1'b0;
    logic [3:0]      wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [3:0]      rd_addr = '0;
    logic [31:0]     rd_data;
    logic            irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [PA_W-1:0] ea_ren, ea_fen, ea_rf, ea_ff;
    logic [PB_W-1:0] eb_ren, eb_fen, eb_rf, eb_ff;

    always #2.5 clk = ~clk;

    gpio_edge_agg #(.PA_W(PA_W), .PB_W(PB_W)) u_gpio_edge_agg (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .ext_irq_req(ext_irq_req), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #0.5;
        check(tag, rd_data, exp);
    endtask

    function automatic logic [31:0] exp_summary();
        return {30'd0, |{eb_rf, eb_ff}, |{ea_rf, ea_ff}};
    endfunction

    task automatic check_all(input string tag);
        reg_chk({tag, " R2 A rise"}, 4'h2, 32'(ea_rf));
        reg_chk({tag, " R3 A fall"}, 4'h3, 32'(ea_ff));
        reg_chk({tag, " R2 B rise"}, 4'hA, 32'(eb_rf));
        reg_chk({tag, " R3 B fall"}, 4'hB, 32'(eb_ff));
        reg_chk({tag, " R8 summary"}, 4'hF, exp_summary());
        check({tag, " R9 irq"}, {31'd0, irq_out},
              {31'd0, ext_irq_req | (|exp_summary())});
    endtask

    task automatic drive_pins(input logic [PA_W-1:0] na, input logic [PB_W-1:0] nb);
        ea_rf |= (na & ~pin_a) & ea_ren;
        ea_ff |= (~na & pin_a) & ea_fen;
        eb_rf |= (nb & ~pin_b) & eb_ren;
        eb_ff |= (~nb & pin_b) & eb_fen;
        pin_a = na; pin_b = nb;
        tick(4);
    endtask

    task automatic set_en(input logic [PA_W-1:0] ar, input logic [PA_W-1:0] af,
                          input logic [PB_W-1:0] br, input logic [PB_W-1:0] bf);
        reg_wr(4'h0, 32'(ar)); reg_wr(4'h1, 32'(af));
        reg_wr(4'h8, 32'(br)); reg_wr(4'h9, 32'(bf));
        ea_ren = ar; ea_fen = af; eb_ren = br; eb_fen = bf;
    endtask

    task automatic clear(input logic [PA_W-1:0] ma, input logic [PB_W-1:0] mb);
        reg_wr(4'h4, 32'(ma)); reg_wr(4'hC, 32'(mb));
        ea_rf &= ~ma; ea_ff &= ~ma; eb_rf &= ~mb; eb_ff &= ~mb;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        ea_ren = '0; ea_fen = '0; ea_rf = '0; ea_ff = '0;
        eb_ren = '0; eb_fen = '0; eb_rf = '0; eb_ff = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        reg_chk("R1 A rise en", 4'h0, 32'd0);
        reg_chk("R1 B fall en", 4'h9, 32'd0);
        check_all("R1 reset");

        // R10: enable readback, limited to pin count
        reg_wr(4'h8, 32'hFFFF_FFFF);
        reg_chk("R10 B rise en readback", 4'h8, 32'h3FF);
        reg_wr(4'h8, 32'd0);
        reg_wr(4'h1, 32'hA5A5_0F0F);
        reg_chk("R10 A fall en readback", 4'h1, 32'hA5A5_0F0F);
        reg_chk("R10 clear reads zero", 4'h4, 32'd0);
        reg_wr(4'h1, 32'd0);

        // R5: edges with nothing enabled
        drive_pins('1, '1);
        drive_pins('0, '0);
        check_all("R5 disabled");

        // R2 R3 R4: directed
        set_en(32'h0000_00F0, 32'h0000_0030, 10'h003, 10'h201);
        drive_pins(32'h0000_00FF, 10'h3FF);
        check_all("R2 directed rise");
        drive_pins(32'h0000_0000, 10'h000);
        check_all("R4 directed both");
        // R6: partial clear
        clear(32'h0000_0010, 10'h001);
        check_all("R6 partial clear");
        clear('1, '1);
        check_all("R6 full clear");

        // R7: edge in same cycle as clear
        set_en(32'h0000_0060, 32'd0, '0, '0);
        drive_pins(32'h0000_0040, '0);      // flag on pin 6
        pin_a = 32'h0000_0060;              // rising on pin 5
        tick(2);
        wr_en = 1'b1; wr_addr = 4'h4; wr_data = 32'h0000_0060;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        tick(2);
        reg_chk("R7 edge wins over clear", 4'h2, 32'h0000_0020);
        ea_rf = 32'h0000_0020;
        clear('1, '1);

        // R9: external request alone
        ext_irq_req = 1'b1;
        #0.5;
        check("R9 ext alone", {31'd0, irq_out}, 32'd1);
        ext_irq_req = 1'b0;
        #0.5;
        check("R9 ext dropped", {31'd0, irq_out}, 32'd0);

        // Random phase
        for (int it = 0; it < 60; it++) begin
            if (($urandom % 4) == 0)
                set_en($urandom, $urandom, PB_W'($urandom), PB_W'($urandom));
            ext_irq_req = (($urandom % 5) == 0);
            drive_pins($urandom, PB_W'($urandom));
            check_all("random");
            if (($urandom % 3) == 0) begin
                clear($urandom, PB_W'($urandom));
                check_all("R6 random clear");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule